// File: doc/BRIEF.md
# Coin Credit Counter with Two-Digit Display

This block turns a single raw push button into a count of quarter coins and shows the running credit on two seven-segment digits. Every press is brought into the clock domain through a two-flop synchronizer. It is then reduced to a one-cycle pulse on its rising edge, so a press counts once however long the button is held. A new coin needs the button to be released and pressed again.

The count goes from zero to four and then stays at four. Further presses are ignored until the synchronous reset clears the count. The two digits show the credit in cents while it is below one dollar. At the full dollar they show "10", read as 1.0 dollars. The press count is also driven out as a binary value.

Top module: `coin_credit_display`

## Requirements
- R1: While `rst` is high at a rising clock edge, the count, the synchronizer flops and the edge-detect flop are cleared. After reset, `coin_count` is 0 and both digits show 0 until the first press is counted.
- R2: When `coin_btn` rises, `coin_count` goes up by exactly one. The new value appears after the third rising clock edge that samples the button high: two edges for the synchronizer and one for the counter. After the first and second of those edges, `coin_count` still holds its old value.
- R3: A button held high for any number of cycles adds exactly one coin. A further coin needs a low period of at least two cycles and then a new rise.
- R4: The count saturates at 4. A press made at count 4 leaves `coin_count` at 4.
- R5: The digits depend on the count. Count 0 shows left 0 and right 0. Count 1 shows 2 and 5. Count 2 shows 5 and 0. Count 3 shows 7 and 5. Count 4 shows 1 and 0.
- R6: Segment outputs are active-high, with the bit order {dp,g,f,e,d,c,b,a} from bit 7 down to bit 0, and the decimal point is always off. The digit patterns are: 0 = 8'h3F, 1 = 8'h06, 2 = 8'h5B, 5 = 8'h6D, 7 = 8'h07.
- R7: A falling edge of the button, and any stretch with the button low, leave `coin_count` and both digits unchanged.
- R8: If the button is held high while reset is released, this counts as one new press. The count then reads 1 after the third clock edge that samples the button with reset low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| coin_btn | input | 1 | Raw coin button, asynchronous to `clk` |
| coin_count | output | 3 | Number of coins counted (0 to 4) |
| seg_left | output | 8 | Left digit segments {dp,g,f,e,d,c,b,a}, active high |
| seg_right | output | 8 | Right digit segments {dp,g,f,e,d,c,b,a}, active high |

## Verification
A stuck or doubled edge pulse shows up as a second increment during a long hold. It also shows up as a missed increment after a fresh press. Either one appears at `coin_count` three cycles after the button rises. A wrong saturation limit appears at the fifth press, as a count of 5 or a wrapped digit pair. A mistake in the display table appears as soon as the count reaches the affected value, because the segments are combinational from the count. An extra or missing synchronizer stage moves the count change by one cycle. The latency check catches this on the first press.

// File: rtl/coin_credit_pkg.sv
package coin_credit_pkg;

  localparam int COIN_CENTS = 25;

  // Active-high segments, bit order {dp,g,f,e,d,c,b,a}; dp kept low.
  function automatic logic [7:0] seg_encode(input logic [3:0] digit);
    logic [7:0] pat;
    case (digit)
      4'd0:    pat = 8'h3F;
      4'd1:    pat = 8'h06;
      4'd2:    pat = 8'h5B;
      4'd3:    pat = 8'h4F;
      4'd4:    pat = 8'h66;
      4'd5:    pat = 8'h6D;
      4'd6:    pat = 8'h7D;
      4'd7:    pat = 8'h07;
      4'd8:    pat = 8'h7F;
      4'd9:    pat = 8'h6F;
      default: pat = 8'h00;
    endcase
    return pat;
  endfunction

  // Credit in cents below one dollar; at or above, dollars and dimes.
  function automatic logic [3:0] credit_left(input int coins);
    int cents;
    cents = coins * COIN_CENTS;
    if (cents < 100) return 4'(cents / 10);
    return 4'((cents / 100) % 10);
  endfunction

  function automatic logic [3:0] credit_right(input int coins);
    int cents;
    cents = coins * COIN_CENTS;
    if (cents < 100) return 4'(cents % 10);
    return 4'((cents % 100) / 10);
  endfunction

endpackage

// File: rtl/coin_btn_edge.sv
module coin_btn_edge #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic btn_raw,
  output logic btn_sync,
  output logic press_pulse
);

  logic [SYNC_STAGES-1:0] sync_chain;
  logic                   prev_q;

  generate
    for (genvar s = 0; s < SYNC_STAGES; s++) begin : g_stage
      if (s == 0) begin : g_first
        always_ff @(posedge clk) begin
          if (rst) sync_chain[0] <= 1'b0;
          else     sync_chain[0] <= btn_raw;
        end
      end else begin : g_next
        always_ff @(posedge clk) begin
          if (rst) sync_chain[s] <= 1'b0;
          else     sync_chain[s] <= sync_chain[s-1];
        end
      end
    end
  endgenerate

  assign btn_sync = sync_chain[SYNC_STAGES-1];

  always_ff @(posedge clk) begin
    if (rst) prev_q <= 1'b0;
    else     prev_q <= btn_sync;
  end

  assign press_pulse = btn_sync & ~prev_q;

  AST_PULSE_SINGLE: assert property (@(posedge clk) disable iff (rst)
    press_pulse |=> !press_pulse) else $error("edge pulse lasted two cycles"); // R3

endmodule

// File: rtl/coin_sat_counter.sv
module coin_sat_counter #(
  parameter int MAX_COINS = 4,
  localparam int CNT_W = $clog2(MAX_COINS + 1)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             press_pulse,
  output logic [CNT_W-1:0] count
);

  localparam logic [CNT_W-1:0] FULL = CNT_W'(MAX_COINS);

  logic inc_en;
  assign inc_en = press_pulse & (count != FULL);

  always_ff @(posedge clk) begin
    if (rst)         count <= '0;
    else if (inc_en) count <= count + 1'b1;
  end

  AST_STEP_ONE: assert property (@(posedge clk) disable iff (rst)
    inc_en |=> count == $past(count) + 1'b1) else $error("count did not step by one"); // R2
  AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (rst)
    !press_pulse |=> $stable(count)) else $error("count moved without a press"); // R7
  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (rst)
    count <= FULL) else $error("count above limit"); // R4
  AST_SAT_HOLD: assert property (@(posedge clk) disable iff (rst)
    (count == FULL) |=> count == FULL) else $error("count left saturation"); // R4

endmodule

// File: rtl/coin_credit_digits.sv
module coin_credit_digits
  import coin_credit_pkg::*;
#(
  parameter int CNT_W = 3
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [CNT_W-1:0] count,
  output logic [7:0]       seg_left,
  output logic [7:0]       seg_right
);

  logic [3:0] digit_l, digit_r;

  always_comb begin
    digit_l   = credit_left(int'(count));
    digit_r   = credit_right(int'(count));
    seg_left  = seg_encode(digit_l);
    seg_right = seg_encode(digit_r);
  end

  AST_DP_OFF: assert property (@(posedge clk) disable iff (rst)
    !seg_left[7] && !seg_right[7]) else $error("decimal point lit"); // R6
  AST_ZERO_SHOWS_00: assert property (@(posedge clk) disable iff (rst)
    (count == '0) |-> (seg_left == 8'h3F && seg_right == 8'h3F)) else $error("zero credit not 00"); // R5

endmodule

// File: rtl/coin_credit_display.sv
module coin_credit_display #(
  parameter int SYNC_STAGES = 2,
  parameter int MAX_COINS   = 4,
  localparam int CNT_W      = $clog2(MAX_COINS + 1)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             coin_btn,
  output logic [CNT_W-1:0] coin_count,
  output logic [7:0]       seg_left,
  output logic [7:0]       seg_right
);

  logic btn_sync;
  logic press_pulse;

  coin_btn_edge #(.SYNC_STAGES(SYNC_STAGES)) u_edge (
    .clk         (clk),
    .rst         (rst),
    .btn_raw     (coin_btn),
    .btn_sync    (btn_sync),
    .press_pulse (press_pulse)
  );

  coin_sat_counter #(.MAX_COINS(MAX_COINS)) u_count (
    .clk         (clk),
    .rst         (rst),
    .press_pulse (press_pulse),
    .count       (coin_count)
  );

  coin_credit_digits #(.CNT_W(CNT_W)) u_digits (
    .clk       (clk),
    .rst       (rst),
    .count     (coin_count),
    .seg_left  (seg_left),
    .seg_right (seg_right)
  );

  AST_PULSE_NEEDS_SYNC: assert property (@(posedge clk) disable iff (rst)
    press_pulse |-> btn_sync) else $error("pulse without synced high"); // R2

endmodule

// File: tb/coin_credit_display_tb.sv
module coin_credit_display_tb;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       coin_btn = 1'b0;
  logic [2:0] coin_count;
  logic [7:0] seg_left, seg_right;

  int checks = 0;
  int errors = 0;

  always #2 clk = ~clk;

  coin_credit_display u_dut (
    .clk(clk), .rst(rst), .coin_btn(coin_btn),
    .coin_count(coin_count), .seg_left(seg_left), .seg_right(seg_right)
  );

  function automatic logic [7:0] exp_seg(input int d);
    case (d)
      0: return 8'h3F;
      1: return 8'h06;
      2: return 8'h5B;
      5: return 8'h6D;
      7: return 8'h07;
      default: return 8'hFF;
    endcase
  endfunction

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic chk_display(input string req, input int coins);
    int cents, l, r;
    cents = coins * 25;
    if (cents < 100) begin l = cents / 10;  r = cents % 10; end
    else             begin l = cents / 100; r = (cents % 100) / 10; end
    chk({req, " left"},  int'(seg_left),  int'(exp_seg(l)));
    chk({req, " right"}, int'(seg_right), int'(exp_seg(r)));
  endtask

  task automatic cycles(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic press_release(input int hold, input int low);
    coin_btn = 1'b1; cycles(hold);
    coin_btn = 1'b0; cycles(low);
  endtask

  initial begin
    #(4 * 200000);
    errors++;
    $display("FAIL watchdog actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    cycles(3);
    rst = 1'b0;
    cycles(1);
    chk("R1 count after reset", int'(coin_count), 0);
    chk_display("R1 R6 display 00", 0);
    chk("R6 dp left off", int'(seg_left[7]), 0);

    // R2 latency: button rises just after a negedge
    coin_btn = 1'b1;
    @(posedge clk); #1 chk("R2 after edge 1", int'(coin_count), 0);
    @(posedge clk); #1 chk("R2 after edge 2", int'(coin_count), 0);
    @(posedge clk); #1 chk("R2 after edge 3", int'(coin_count), 1);
    // R3 long hold
    cycles(40);
    chk("R3 held press one coin", int'(coin_count), 1);
    chk_display("R5 count1", 1);
    coin_btn = 1'b0; cycles(6);
    chk("R7 release no change", int'(coin_count), 1);
    chk_display("R7 display after release", 1);

    // Sweep through saturation, varying hold lengths
    for (int p = 2; p <= 7; p++) begin
      press_release(1 + p, 3 + (p % 3));
      chk((p <= 4) ? "R2 press count" : "R4 saturated count",
          int'(coin_count), (p < 4) ? p : 4);
      chk_display("R5 R6 sweep", (p < 4) ? p : 4);
    end

    // R3 short release gap of two cycles still gives a new press
    rst = 1'b1; cycles(2); rst = 1'b0; cycles(1);
    chk("R1 mid-run reset", int'(coin_count), 0);
    chk_display("R1 display after reset", 0);
    press_release(2, 2);
    press_release(2, 4);
    chk("R3 two presses, 2-cycle gap", int'(coin_count), 2);

    // R8 button held through reset release
    coin_btn = 1'b1; rst = 1'b1; cycles(3);
    chk("R1 reset while held", int'(coin_count), 0);
    rst = 1'b0;
    @(posedge clk); #1 chk("R8 edge 1", int'(coin_count), 0);
    @(posedge clk); #1 chk("R8 edge 2", int'(coin_count), 0);
    @(posedge clk); #1 chk("R8 edge 3", int'(coin_count), 1);
    cycles(10);
    chk("R8 still one", int'(coin_count), 1);
    coin_btn = 1'b0; cycles(4);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule